// File: doc/BRIEF.md
# IF Frequency Window Counter

This block decides whether an intermediate-frequency signal sits close enough to its expected value for a tuner's search to stop on a station. A reference-clock prescaler produces a base tick, a gate divider stretches a number of those ticks into a measurement gate, and a main down-counter counts synchronised rising edges of the IF input during the gate. At the start of each gate the counter is loaded with the number of edges that a correct IF would produce. At the end of the gate the value left in the counter is the error. When that error is small enough, the station-found flag is raised.

The tolerance, the centre trim, the gate length, the prescaler divisor and the measurement mode are static configuration inputs. The enable input starts measurements. Gates follow each other without a gap while enable stays high. The IF input is sampled by the reference clock, so that clock must run at more than twice the IF rate. Set the configuration while enable is low. Raise enable after reset to start the first gate from a freshly loaded counter.

Top module: `ifc_window_counter`

## Requirements
- R1: The measurement mode field `meas_mode` uses these codes: 2'b00 is idle, and no measurement runs. 2'b01 (FM) expects 1696 edges per base tick. 2'b10 (AM) expects 448 edges per base tick. 2'b11 (AM up-conversion) expects 10684 edges per base tick.
- R2: While measuring, one base tick is produced every `tick_div`+1 reference clock cycles.
- R3: A gate lasts 2^min(`gate_sel`,5) base ticks, so codes 6 and 7 behave like 5. `meas_done` is high for exactly one cycle, in the cycle after the gate's last reference cycle. The next gate begins at once.
- R4: At each gate start the main counter is loaded with (per-tick expected count + `center_trim`) × gate ticks. It decrements once for each detected rising edge of `if_in`.
- R5: At the end of a gate, the counter residual (preload minus counted edges, taken as a signed value) is accepted when |residual| <= 2^min(`win_sel`,5). Codes 6 and 7 therefore give a tolerance of 32. Both positive and negative residuals are judged the same way.
- R6: `stop_flag` takes the accept result at each gate end. It holds that value unchanged until the next gate end or an abort.
- R7: `center_trim` (0..31) adds that many edges to the per-tick expected count before scaling by the gate length.
- R8: While `enable` is low, or the mode is idle, `stop_flag` and `meas_done` are low and both counters are reloaded. Dropping `enable` mid-gate abandons that gate with no `meas_done`.
- R9: `if_in` passes through a two-flop synchroniser and a rising-edge detector. A level held high counts as a single edge.
- R10: After reset, `stop_flag` and `meas_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run measurements; low aborts and clears |
| meas_mode | input | 2 | Measurement mode code |
| win_sel | input | 3 | Tolerance window exponent |
| center_trim | input | 5 | Per-tick expected count trim |
| gate_sel | input | 3 | Gate length exponent in base ticks |
| tick_div | input | TIMER_W (14) | Prescaler divisor minus one |
| if_in | input | 1 | Asynchronous IF input |
| stop_flag | output | 1 | Station found, held between gate ends |
| meas_done | output | 1 | One-cycle pulse after each gate |

## Verification
The bench sets IF rates that land a residual just inside or just outside the tolerance, on both sides of zero. A design that took the magnitude wrongly, or that compared only one side, would then accept a station it should reject, or the reverse. Window code 7 is driven with an error of 40 edges, and gate code 7 is run. A design that failed to clamp those codes would accept that error, or would pulse `meas_done` much too late. Other cases cover the centre trim, the FM and up-conversion bases, an IF level held high that must count as one edge, an abort in mid-gate that must clear the flag with no pulse, and an idle mode that must never pulse.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    IFM_IDLE = 2'b00,
    IFM_FM   = 2'b01,
    IFM_AM   = 2'b10,
    IFM_UPC  = 2'b11
  } ifc_mode_e;

  localparam int unsigned BASE_FM   = 1696;
  localparam int unsigned BASE_AM   = 448;
  localparam int unsigned BASE_UPC  = 10684;
  localparam int unsigned MAX_SHIFT = 5;

  function automatic int unsigned clamp_shift(input logic [2:0] code);
    return (code > 3'(MAX_SHIFT)) ? MAX_SHIFT : int'(code);
  endfunction
endpackage

// File: rtl/ifc_if_sync.sv
module ifc_if_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic if_in,
  output logic rise
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], if_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R9: a detected rise can never repeat in the following cycle
  assert_single_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
  parameter int TIMER_W = 14,
  parameter int GSEL_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [TIMER_W-1:0] tick_div,
  input  logic [GSEL_W-1:0]  gate_sel,
  output logic               gate_end
);
  import ifc_pkg::*;
  localparam int GCNT_W = MAX_SHIFT + 1;

  logic [TIMER_W-1:0] tcnt_q, tcnt_d;
  logic [GCNT_W-1:0]  gcnt_q, gcnt_d;
  logic [GCNT_W-1:0]  gate_last;
  logic               tick;

  always_comb begin
    gate_last = GCNT_W'((1 << clamp_shift(gate_sel)) - 1);
    tick      = (tcnt_q >= tick_div);
    gate_end  = run && tick && (gcnt_q >= gate_last);
    tcnt_d    = tcnt_q;
    gcnt_d    = gcnt_q;
    if (!run) begin
      tcnt_d = '0;
      gcnt_d = '0;
    end else begin
      tcnt_d = tick ? '0 : tcnt_q + 1'b1;
      if (tick) gcnt_d = gate_end ? '0 : gcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      gcnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      gcnt_q <= gcnt_d;
    end
  end

  // R3: after a gate closes, both the prescaler and the tick count restart
  assert_gate_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> (tcnt_q == '0) && (gcnt_q == '0));
  // R8: an inactive block holds the timer at rest
  assert_timer_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tcnt_q == '0) && (gcnt_q == '0));
endmodule

// File: rtl/ifc_main_counter.sv
module ifc_main_counter #(
  parameter int MAIN_W = 21,
  parameter int CF_W   = 5,
  parameter int GSEL_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     gate_end,
  input  logic                     rise,
  input  logic [1:0]               meas_mode,
  input  logic [CF_W-1:0]          center_trim,
  input  logic [GSEL_W-1:0]        gate_sel,
  output logic signed [MAIN_W-1:0] residual
);
  import ifc_pkg::*;

  logic [MAIN_W-1:0] cnt_q, cnt_d;
  logic [MAIN_W-1:0] preload;
  int unsigned       per_tick;

  always_comb begin
    case (ifc_mode_e'(meas_mode))
      IFM_FM:  per_tick = BASE_FM;
      IFM_AM:  per_tick = BASE_AM;
      IFM_UPC: per_tick = BASE_UPC;
      default: per_tick = 0;
    endcase
    preload  = MAIN_W'((per_tick + int'(center_trim)) << clamp_shift(gate_sel));
    residual = $signed(cnt_q - MAIN_W'(rise));
    if (!run || gate_end) cnt_d = preload;
    else                  cnt_d = cnt_q - MAIN_W'(rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: each new gate starts from the expected count
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_end || !run) |=> cnt_q == $past(preload));
  // R4: within a gate the counter moves only on a detected edge
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !gate_end && !rise) |=> $stable(cnt_q));
endmodule

// File: rtl/ifc_window_judge.sv
module ifc_window_judge #(
  parameter int MAIN_W   = 21,
  parameter int WIN_STEP = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     gate_end,
  input  logic signed [MAIN_W-1:0] residual,
  input  logic [2:0]               win_sel,
  output logic                     stop_flag,
  output logic                     meas_done
);
  import ifc_pkg::*;

  logic signed [MAIN_W:0] tol;
  logic signed [MAIN_W:0] res_ext;
  logic                   accept;
  logic                   stop_d, done_d;

  always_comb begin
    tol     = (MAIN_W+1)'(WIN_STEP << clamp_shift(win_sel));
    res_ext = {residual[MAIN_W-1], residual};
    accept  = (res_ext <= tol) && (res_ext >= -tol);
    stop_d  = stop_flag;
    done_d  = 1'b0;
    if (!run) begin
      stop_d = 1'b0;
    end else if (gate_end) begin
      stop_d = accept;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_flag <= 1'b0;
      meas_done <= 1'b0;
    end else begin
      stop_flag <= stop_d;
      meas_done <= done_d;
    end
  end

  // R6: the flag changes only at a gate end or when measurement stops
  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag != $past(stop_flag)) |-> ($past(gate_end) || !$past(run)));
  // R8: an inactive cycle leaves both outputs low
  assert_abort_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!stop_flag && !meas_done));
endmodule

// File: rtl/ifc_window_counter.sv
module ifc_window_counter #(
  parameter int TIMER_W     = 14,
  parameter int MAIN_W      = 21,
  parameter int CF_W        = 5,
  parameter int GSEL_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_STEP    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         meas_mode,
  input  logic [2:0]         win_sel,
  input  logic [CF_W-1:0]    center_trim,
  input  logic [GSEL_W-1:0]  gate_sel,
  input  logic [TIMER_W-1:0] tick_div,
  input  logic               if_in,
  output logic               stop_flag,
  output logic               meas_done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       run;
  logic       rise;
  logic       gate_end;
  logic signed [MAIN_W-1:0] residual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign run = enable && (meas_mode != 2'b00);

  ifc_if_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .if_in(if_in), .rise(rise)
  );

  ifc_gate_timer #(.TIMER_W(TIMER_W), .GSEL_W(GSEL_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .run(run), .tick_div(tick_div),
    .gate_sel(gate_sel), .gate_end(gate_end)
  );

  ifc_main_counter #(.MAIN_W(MAIN_W), .CF_W(CF_W), .GSEL_W(GSEL_W)) u_main (
    .clk(clk), .rst_n(rst_int_n), .run(run), .gate_end(gate_end), .rise(rise),
    .meas_mode(meas_mode), .center_trim(center_trim), .gate_sel(gate_sel),
    .residual(residual)
  );

  ifc_window_judge #(.MAIN_W(MAIN_W), .WIN_STEP(WIN_STEP)) u_judge (
    .clk(clk), .rst_n(rst_int_n), .run(run), .gate_end(gate_end),
    .residual(residual), .win_sel(win_sel),
    .stop_flag(stop_flag), .meas_done(meas_done)
  );

  // R1: the idle mode code never produces a measurement
  assert_idle_mode_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (meas_mode == 2'b00) |=> !meas_done);
endmodule

// File: tb/ifc_window_counter_test.sv
module ifc_window_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    meas_mode = 2'b10;
  logic [2:0]    win_sel = 3'd0;
  logic [4:0]    center_trim = 5'd0;
  logic [2:0]    gate_sel = 3'd0;
  logic [TW-1:0] tick_div = TW'(895);
  logic          if_in = 1'b0;
  logic          stop_flag, meas_done;

  int if_style = 0;   // 0 low, 1 toggle each cycle, 2 held high
  int vectors = 0;
  int errors = 0;
  bit compare_on = 0;
  bit finished = 0;

  // reference model state
  int m_s1 = 0, m_s2 = 0, m_s3 = 0;
  int m_tcnt = 0, m_gcnt = 0, m_cnt = 0;
  int m_stop = 0, m_done = 0;

  ifc_window_counter #(.TIMER_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .meas_mode(meas_mode),
    .win_sel(win_sel), .center_trim(center_trim), .gate_sel(gate_sel),
    .tick_div(tick_div), .if_in(if_in),
    .stop_flag(stop_flag), .meas_done(meas_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int shift_of(input int code);
    return (code > 5) ? 5 : code;
  endfunction

  function automatic int expect_load();
    int base;
    case (meas_mode)
      2'b01: base = 1696;
      2'b10: base = 448;
      2'b11: base = 10684;
      default: base = 0;
    endcase
    return (base + int'(center_trim)) * (1 << shift_of(int'(gate_sel)));
  endfunction

  always @(negedge clk) begin
    if (if_style == 1)      if_in <= ~if_in;
    else if (if_style == 2) if_in <= 1'b1;
    else                    if_in <= 1'b0;
  end

  always @(posedge clk) begin
    int edge_now, running, tick, gend, fin, tol;
    edge_now = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(if_in);
    running = (enable && meas_mode != 2'b00) ? 1 : 0;
    if (!running) begin
      m_tcnt = 0; m_gcnt = 0; m_cnt = expect_load(); m_stop = 0; m_done = 0;
    end else begin
      tick = (m_tcnt >= int'(tick_div)) ? 1 : 0;
      gend = (tick && m_gcnt >= (1 << shift_of(int'(gate_sel))) - 1) ? 1 : 0;
      m_tcnt = tick ? 0 : m_tcnt + 1;
      if (tick) m_gcnt = gend ? 0 : m_gcnt + 1;
      fin = m_cnt - edge_now;
      if (gend) begin
        tol = 1 << shift_of(int'(win_sel));
        m_stop = (fin <= tol && fin >= -tol) ? 1 : 0;
        m_done = 1;
        m_cnt = expect_load();
      end else begin
        m_done = 0;
        m_cnt = fin;
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      vectors++;
      if (int'(stop_flag) != m_stop) begin
        errors++;
        $display("FAIL R5 stop_flag act=%0d exp=%0d at %0t", stop_flag, m_stop, $time);
      end
      if (int'(meas_done) != m_done) begin
        errors++;
        $display("FAIL R3 meas_done act=%0d exp=%0d at %0t", meas_done, m_done, $time);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic start_case(input logic [1:0] md, input int cf, input int gs,
                            input int ew, input int td, input int style);
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    meas_mode = md; center_trim = 5'(cf); gate_sel = 3'(gs);
    win_sel = 3'(ew); tick_div = TW'(td); if_style = style;
    repeat (4) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic wait_done(input int limit, output int waited);
    waited = 0;
    @(negedge clk);
    while (!meas_done && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic run_case(input logic [1:0] md, input int cf, input int gs, input int ew,
                          input int td, input int style, input int exp_stop, input string req);
    int w, gate_cycles;
    gate_cycles = (td + 1) * (1 << shift_of(gs));
    start_case(md, cf, gs, ew, td, style);
    wait_done(gate_cycles + 50, w);
    check(meas_done == 1'b1, {req, " done"}, int'(meas_done), 1);
    check(int'(stop_flag) == exp_stop, {req, " stop"}, int'(stop_flag), exp_stop);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: outputs low after reset
    check(stop_flag == 1'b0 && meas_done == 1'b0, "R10 reset", int'(stop_flag), 0);
    compare_on = 1;

    // R5: exact AM count, window code 0
    run_case(2'b10, 0, 0, 0, 895, 1, 1, "R5 exact");
    // R6: flag held between gate ends
    repeat (300) @(negedge clk);
    check(stop_flag == 1'b1, "R6 hold", int'(stop_flag), 1);
    // R5: about +5 residual, tolerance 1
    run_case(2'b10, 0, 0, 0, 885, 1, 0, "R5 low rate");
    // R5: same error, window code 3 gives 8
    run_case(2'b10, 0, 0, 3, 885, 1, 1, "R5 wider");
    // R5: about -20 residual, tolerance 16
    run_case(2'b10, 0, 0, 4, 935, 1, 0, "R5 negative");
    // R5: about -40 residual, code 7 clamps to 32
    run_case(2'b10, 0, 0, 7, 975, 1, 0, "R5 clamp");
    // R7: trim of 20 matches 468 edges
    run_case(2'b10, 20, 0, 0, 935, 1, 1, "R7 trim");
    // R1 R4: FM base, trim 4, two ticks
    run_case(2'b01, 4, 1, 1, 3399, 1, 1, "R1 fm");
    // R1: up-conversion base
    run_case(2'b11, 0, 0, 1, 21367, 1, 1, "R1 upc");
    // R3: gate code 7 acts as 32 ticks; R2 tick length
    start_case(2'b10, 0, 7, 0, 895, 1);
    wait_done(40000, w);
    check(meas_done == 1'b1 && w >= 32*896 - 8 && w <= 32*896 + 8, "R3 gate clamp", w, 32*896);
    check(stop_flag == 1'b1, "R2 tick length", int'(stop_flag), 1);
    // R9: held-high input counts once -> far off
    run_case(2'b10, 0, 0, 5, 895, 2, 0, "R9 level");
    // R8: abort mid gate
    start_case(2'b10, 0, 0, 0, 895, 1);
    wait_done(2000, w);
    repeat (400) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(stop_flag == 1'b0, "R8 abort clear", int'(stop_flag), 0);
    w = 0;
    repeat (1000) begin
      @(negedge clk);
      if (meas_done) w++;
    end
    check(w == 0, "R8 no done", w, 0);
    // R1: idle mode never measures
    start_case(2'b00, 0, 0, 0, 100, 1);
    w = 0;
    repeat (1500) begin
      @(negedge clk);
      if (meas_done) w++;
    end
    check(w == 0 && stop_flag == 1'b0, "R1 idle", w, 0);

    compare_on = 0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule